// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block sits next to a small 32-bit CPU core and decides, once per clock, whether the core must be redirected by a hardware reset request, a non-maskable interrupt (NMI) or one of six maskable interrupt requests. It looks at the core's current program counter, status word (PSW) and exception cause register. When it accepts an event, it produces a one-cycle redirect strobe with the vector address, the new PSW and cause values, and write strobes with data for one of two save banks. One bank holds the NMI save-PC/PSW pair and the other holds the maskable save-PC/PSW pair.

The core must load the new PSW, the cause value and the save registers in the cycle the strobe is high. All outputs are registered. In the cycle its strobe is high, the block ignores its inputs, because the core's PSW input still shows the pre-entry value until the next edge. NMI requests are edge-detected into a single pending flag. Maskable requests are level-sensitive, and the requesting device must hold its line until it is served.

Top module: `irq_entry_ctrl`

## Requirements
- R1: One cycle after `hw_reset_i` is sampled high (and no strobe is active), `redirect_o` pulses with target 0x0, PSW 0x00000020 and cause 0. No save strobe is asserted, and any pending NMI is discarded.
- R2: An NMI is taken when NP (PSW bit 7) is clear. The NMI save bank receives the current PC and PSW. The new PSW has NP=1, ID=1 (bit 5) and EP=0 (bit 6), with all other bits kept. The target is 0x10.
- R3: On NMI entry the new cause has its upper 16 bits zero and its lower 16 bits equal to the old lower half OR 0x0010.
- R4: A rising edge on `nmi_i` while NP is set stays pending and is retried every cycle. However many edges arrive while NP is set, exactly one NMI entry follows once NP clears.
- R5: A maskable request is not taken while NP or ID is set. It is taken once both are clear, as long as the line is still high.
- R6: On maskable entry the maskable save bank receives the current PC and PSW. The new PSW has ID=1 and EP=0, with all other bits kept.
- R7: Maskable source k (bit k of `irq_i`, k=0..5) vectors to 0x80+0x10*k. The new cause keeps the old upper 16 bits and has its lower 16 bits replaced by the same value 0x80+0x10*k.
- R8: Priority is fixed: reset over NMI over maskable requests, and among maskable requests the lowest index wins.
- R9: `redirect_o` is never high on two consecutive cycles. Inputs sampled while it is high cause no entry. Each save strobe is high only together with `redirect_o`, and never both save strobes at once.
- R10: While `rst_ni` is low, all outputs are 0 and the NMI edge and pending state is cleared.
- R11: An `nmi_i` level held high yields only one NMI entry. A new request needs a fresh low-to-high transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_reset_i | input | 1 | Synchronous hardware reset request (level) |
| nmi_i | input | 1 | NMI request, edge-detected |
| irq_i | input | 6 | Maskable requests, level-sensitive, bit 0 highest priority |
| pc_i | input | 32 | Current program counter |
| psw_i | input | 32 | Current status word |
| cause_i | input | 32 | Current exception cause register |
| redirect_o | output | 1 | One-cycle redirect strobe |
| target_o | output | 32 | Vector address, valid with redirect_o |
| psw_o | output | 32 | New PSW, valid with redirect_o |
| cause_o | output | 32 | New cause value, valid with redirect_o |
| nmi_save_we_o | output | 1 | Write strobe for NMI save bank |
| nmi_save_pc_o | output | 32 | PC to save in NMI bank |
| nmi_save_psw_o | output | 32 | PSW to save in NMI bank |
| irq_save_we_o | output | 1 | Write strobe for maskable save bank |
| irq_save_pc_o | output | 32 | PC to save in maskable bank |
| irq_save_psw_o | output | 32 | PSW to save in maskable bank |

## Verification
The bench pulses `nmi_i` twice while NP is set and then clears NP. A design that counted edges would produce a second NMI entry, and one that dropped the pending request would produce none. Maskable lines are held with a PSW the core never updates, so the entries must alternate with idle cycles. A design without the strobe-cycle block would enter on back-to-back cycles and save a stale PSW. Simultaneous reset, NMI and multiple maskable requests check the priority order and that reset discards a pending NMI. A cause value with both halves populated catches swapped or unmasked halves. A held NMI level and an asynchronous reset while an NMI is pending catch level-triggering and stale pending state.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ENT_NONE  = 2'd0,
    ENT_RESET = 2'd1,
    ENT_NMI   = 2'd2,
    ENT_IRQ   = 2'd3
  } entry_kind_e;
endpackage

// File: rtl/irq_nmi_tracker.sv
module irq_nmi_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clear_i,
  output logic req_o
);
  logic nmi_q, pend_q, edge_w;

  assign edge_w = nmi_i & ~nmi_q;
  assign req_o  = pend_q | edge_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= clear_i ? 1'b0 : (pend_q | edge_w);
    end
  end

  p_pend_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clear_i) |=> pend_q);
  p_no_level_retrigger_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && nmi_q && nmi_i) |=> !pend_q);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = 6,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end
  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) idx_o = IDX_W'(i);
  end

  p_grant_onehot_r8: assert property (@(req_i) 1'b1 |-> $onehot0(grant))
    else $error("grant not one-hot");
endmodule

// File: rtl/irq_entry_calc.sv
module irq_entry_calc
  import irq_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              N_IRQ     = 6,
  parameter int              IDX_W     = 3,
  parameter int              NP_BIT    = 7,
  parameter int              EP_BIT    = 6,
  parameter int              ID_BIT    = 5,
  parameter logic [XLEN-1:0] RESET_PSW = 'h20,
  parameter logic [XLEN-1:0] NMI_VEC   = 'h10,
  parameter logic [XLEN-1:0] NMI_CODE  = 'h10,
  parameter logic [XLEN-1:0] VEC_BASE  = 'h80,
  parameter logic [XLEN-1:0] VEC_STEP  = 'h10
) (
  input  entry_kind_e      kind_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  psw_i,
  input  logic [XLEN-1:0]  cause_i,
  output logic [XLEN-1:0]  target_o,
  output logic [XLEN-1:0]  psw_o,
  output logic [XLEN-1:0]  cause_o
);
  localparam int HALF = XLEN / 2;
  logic [XLEN-1:0] irq_vec;

  assign irq_vec = VEC_BASE + XLEN'(idx_i) * VEC_STEP;

  always_comb begin
    target_o = '0;
    psw_o    = '0;
    cause_o  = '0;
    unique case (kind_i)
      ENT_RESET: psw_o = RESET_PSW;
      ENT_NMI: begin
        target_o         = NMI_VEC;
        psw_o            = psw_i;
        psw_o[NP_BIT]    = 1'b1;
        psw_o[ID_BIT]    = 1'b1;
        psw_o[EP_BIT]    = 1'b0;
        cause_o          = {{(XLEN-HALF){1'b0}}, cause_i[HALF-1:0]} | NMI_CODE;
      end
      ENT_IRQ: begin
        target_o      = irq_vec;
        psw_o         = psw_i;
        psw_o[ID_BIT] = 1'b1;
        psw_o[EP_BIT] = 1'b0;
        cause_o       = {cause_i[XLEN-1:HALF], irq_vec[HALF-1:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              N_IRQ     = 6,
  parameter int              NP_BIT    = 7,
  parameter int              EP_BIT    = 6,
  parameter int              ID_BIT    = 5,
  parameter logic [XLEN-1:0] RESET_PSW = 'h20,
  parameter logic [XLEN-1:0] NMI_VEC   = 'h10,
  parameter logic [XLEN-1:0] NMI_CODE  = 'h10,
  parameter logic [XLEN-1:0] VEC_BASE  = 'h80,
  parameter logic [XLEN-1:0] VEC_STEP  = 'h10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_reset_i,
  input  logic             nmi_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  psw_i,
  input  logic [XLEN-1:0]  cause_i,
  output logic             redirect_o,
  output logic [XLEN-1:0]  target_o,
  output logic [XLEN-1:0]  psw_o,
  output logic [XLEN-1:0]  cause_o,
  output logic             nmi_save_we_o,
  output logic [XLEN-1:0]  nmi_save_pc_o,
  output logic [XLEN-1:0]  nmi_save_psw_o,
  output logic             irq_save_we_o,
  output logic [XLEN-1:0]  irq_save_pc_o,
  output logic [XLEN-1:0]  irq_save_psw_o
);
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  entry_kind_e      kind;
  logic             nmi_req, irq_any;
  logic [IDX_W-1:0] irq_idx;
  logic [XLEN-1:0]  nx_target, nx_psw, nx_cause;

  irq_nmi_tracker u_nmi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nmi_i   (nmi_i),
    .clear_i (kind == ENT_NMI || kind == ENT_RESET),
    .req_o   (nmi_req)
  );

  irq_prio_pick #(.N(N_IRQ), .IDX_W(IDX_W)) u_pick (
    .req_i (irq_i),
    .any_o (irq_any),
    .idx_o (irq_idx)
  );

  // the strobe cycle is blind: psw_i still holds the pre-entry value
  always_comb begin
    kind = ENT_NONE;
    if (!redirect_o) begin
      if (hw_reset_i)                                 kind = ENT_RESET;
      else if (nmi_req && !psw_i[NP_BIT])             kind = ENT_NMI;
      else if (irq_any && !psw_i[NP_BIT] && !psw_i[ID_BIT]) kind = ENT_IRQ;
    end
  end

  irq_entry_calc #(
    .XLEN(XLEN), .N_IRQ(N_IRQ), .IDX_W(IDX_W),
    .NP_BIT(NP_BIT), .EP_BIT(EP_BIT), .ID_BIT(ID_BIT),
    .RESET_PSW(RESET_PSW), .NMI_VEC(NMI_VEC), .NMI_CODE(NMI_CODE),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_calc (
    .kind_i   (kind),
    .idx_i    (irq_idx),
    .psw_i    (psw_i),
    .cause_i  (cause_i),
    .target_o (nx_target),
    .psw_o    (nx_psw),
    .cause_o  (nx_cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o     <= 1'b0;
      target_o       <= '0;
      psw_o          <= '0;
      cause_o        <= '0;
      nmi_save_we_o  <= 1'b0;
      nmi_save_pc_o  <= '0;
      nmi_save_psw_o <= '0;
      irq_save_we_o  <= 1'b0;
      irq_save_pc_o  <= '0;
      irq_save_psw_o <= '0;
    end else begin
      redirect_o     <= (kind != ENT_NONE);
      target_o       <= nx_target;
      psw_o          <= nx_psw;
      cause_o        <= nx_cause;
      nmi_save_we_o  <= (kind == ENT_NMI);
      nmi_save_pc_o  <= (kind == ENT_NMI) ? pc_i  : '0;
      nmi_save_psw_o <= (kind == ENT_NMI) ? psw_i : '0;
      irq_save_we_o  <= (kind == ENT_IRQ);
      irq_save_pc_o  <= (kind == ENT_IRQ) ? pc_i  : '0;
      irq_save_psw_o <= (kind == ENT_IRQ) ? psw_i : '0;
    end
  end

  p_reset_entry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_reset_i && !redirect_o) |=> (redirect_o && target_o == '0 && psw_o == RESET_PSW
                                      && !nmi_save_we_o && !irq_save_we_o));
  p_nmi_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_i[NP_BIT] |=> !nmi_save_we_o);
  p_irq_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_i[NP_BIT] || psw_i[ID_BIT]) |=> !irq_save_we_o);
  p_nmi_over_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!redirect_o && !hw_reset_i && nmi_req && !psw_i[NP_BIT]) |=> nmi_save_we_o);
  p_no_back_to_back_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);
  p_save_with_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_save_we_o || irq_save_we_o) |-> (redirect_o && $countones({nmi_save_we_o, irq_save_we_o}) == 1));
  p_nmi_target_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_save_we_o |-> (target_o == NMI_VEC && psw_o[NP_BIT] && psw_o[ID_BIT] && !psw_o[EP_BIT]));
endmodule

// File: tb/tb_irq_entry_ctrl.sv
module tb_irq_entry_ctrl;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        hw_reset_i = 1'b0, nmi_i = 1'b0;
  logic [5:0]  irq_i = '0;
  logic [31:0] pc_i = '0, psw_i = '0, cause_i = '0;
  logic        redirect_o, nmi_save_we_o, irq_save_we_o;
  logic [31:0] target_o, psw_o, cause_o;
  logic [31:0] nmi_save_pc_o, nmi_save_psw_o, irq_save_pc_o, irq_save_psw_o;

  always #2.5 clk = ~clk;

  irq_entry_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .hw_reset_i(hw_reset_i), .nmi_i(nmi_i), .irq_i(irq_i),
    .pc_i(pc_i), .psw_i(psw_i), .cause_i(cause_i),
    .redirect_o(redirect_o), .target_o(target_o), .psw_o(psw_o), .cause_o(cause_o),
    .nmi_save_we_o(nmi_save_we_o), .nmi_save_pc_o(nmi_save_pc_o), .nmi_save_psw_o(nmi_save_psw_o),
    .irq_save_we_o(irq_save_we_o), .irq_save_pc_o(irq_save_pc_o), .irq_save_psw_o(irq_save_psw_o)
  );

  typedef struct packed {
    logic        redir;
    logic [31:0] tgt, psw, cause;
    logic        nwe;
    logic [31:0] npc, npsw;
    logic        iwe;
    logic [31:0] ipc, ipsw;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  logic  m_prev = 1'b0, m_pend = 1'b0, m_busy = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected registered result
  task automatic drive(input logic rst, input logic nmi, input logic [5:0] irq,
                       input logic [31:0] pc, input logic [31:0] psw,
                       input logic [31:0] cause, input string tag);
    exp_t e;
    logic edge_v, req;
    @(negedge clk);
    hw_reset_i = rst; nmi_i = nmi; irq_i = irq; pc_i = pc; psw_i = psw; cause_i = cause;
    e = '0;
    edge_v = nmi & ~m_prev;
    m_prev = nmi;
    req = m_pend | edge_v;
    m_pend = req;
    if (!m_busy) begin
      if (rst) begin
        e.redir = 1'b1; e.psw = 32'h20; m_pend = 1'b0;
      end else if (req && !psw[7]) begin
        e.redir = 1'b1; e.tgt = 32'h10;
        e.psw = (psw | 32'hA0) & ~32'h40;
        e.cause = {16'h0, cause[15:0] | 16'h0010};
        e.nwe = 1'b1; e.npc = pc; e.npsw = psw;
        m_pend = 1'b0;
      end else if (irq != 0 && !psw[7] && !psw[5]) begin
        int k = 0;
        for (int i = 5; i >= 0; i--) if (irq[i]) k = i;
        e.redir = 1'b1; e.tgt = 32'h80 + 32'h10 * k;
        e.psw = (psw | 32'h20) & ~32'h40;
        e.cause = {cause[31:16], 16'h80 + 16'h10 * k[15:0]};
        e.iwe = 1'b1; e.ipc = pc; e.ipsw = psw;
      end
    end
    m_busy = e.redir;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input logic [31:0] psw, input string tag);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 6'h0, 32'h0, psw, 32'h0, tag);
  endtask

  // monitor: pops one expectation per cycle, 1 ns after the active edge
  always begin
    @(posedge clk);
    #1;
    if (rst_ni && exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(redirect_o === e.redir, t, "redirect", 32'(redirect_o), 32'(e.redir));
      chk(target_o === e.tgt, t, "target", target_o, e.tgt);
      chk(psw_o === e.psw, t, "psw", psw_o, e.psw);
      chk(cause_o === e.cause, t, "cause", cause_o, e.cause);
      chk(nmi_save_we_o === e.nwe && nmi_save_pc_o === e.npc && nmi_save_psw_o === e.npsw,
          t, "nmi_save pc", nmi_save_pc_o, e.npc);
      chk(irq_save_we_o === e.iwe && irq_save_pc_o === e.ipc && irq_save_psw_o === e.ipsw,
          t, "irq_save pc", irq_save_pc_o, e.ipc);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #12;
    chk(redirect_o === 1'b0 && nmi_save_we_o === 1'b0 && irq_save_we_o === 1'b0,
        "R10", "reset outputs", 32'(redirect_o), 32'h0);
    chk(target_o === 32'h0 && psw_o === 32'h0, "R10", "reset target", target_o, 32'h0);
    @(negedge clk); rst_ni = 1'b1;

    // R1 reset entry with populated cause
    drive(1'b1, 1'b0, 6'h0, 32'h400, 32'h0, 32'hDEAD_BEEF, "R1");
    idle(2, 32'h0, "R1_idle");
    // R2 R3 NMI entry: EP set in old PSW, both cause halves populated
    drive(1'b0, 1'b1, 6'h0, 32'h1234, 32'h0000_0041, 32'hABCD_5603, "R2_R3");
    drive(1'b0, 1'b0, 6'h0, 32'h0, 32'h0, 32'h0, "R2_after");
    // R4: two edges while NP set, then release -> exactly one entry
    drive(1'b0, 1'b1, 6'h0, 32'h2000, 32'h80, 32'h0, "R4_edge1");
    drive(1'b0, 1'b0, 6'h0, 32'h2000, 32'h80, 32'h0, "R4_hold");
    drive(1'b0, 1'b1, 6'h0, 32'h2000, 32'h80, 32'h0, "R4_edge2");
    drive(1'b0, 1'b0, 6'h0, 32'h2000, 32'h80, 32'h0, "R4_hold");
    drive(1'b0, 1'b0, 6'h0, 32'h2004, 32'h0, 32'h0, "R4_take");
    idle(3, 32'h0, "R4_once");
    // R6 R7 each source alone
    for (int k = 0; k < 6; k++) begin
      drive(1'b0, 1'b0, 6'(1 << k), 32'h3000 + k, 32'h0000_0100, 32'h7777_1111, "R6_R7");
      idle(1, 32'h0, "R7_gap");
    end
    // R5 masked by ID, then by NP, then released
    drive(1'b0, 1'b0, 6'h08, 32'h500, 32'h20, 32'h0, "R5_id");
    drive(1'b0, 1'b0, 6'h08, 32'h500, 32'h80, 32'h0, "R5_np");
    drive(1'b0, 1'b0, 6'h08, 32'h504, 32'h0, 32'h0, "R5_release");
    idle(1, 32'h0, "R5_gap");
    // R8 priorities
    drive(1'b0, 1'b0, 6'h3C, 32'h600, 32'h0, 32'h0, "R8_lowest");
    idle(1, 32'h0, "R8_gap");
    drive(1'b0, 1'b1, 6'h01, 32'h604, 32'h0, 32'h0, "R8_nmi");
    drive(1'b0, 1'b0, 6'h0, 32'h0, 32'h0, 32'h0, "R8_gap");
    drive(1'b1, 1'b1, 6'h01, 32'h608, 32'h0, 32'h0, "R8_reset");
    // R1 pending NMI discarded by reset; R11 held level does not retrigger
    drive(1'b0, 1'b1, 6'h0, 32'h0, 32'h0, 32'h0, "R1_discard");
    idle(2, 32'h0, "R1_R11_none");
    // R11 held NMI level
    drive(1'b0, 1'b1, 6'h0, 32'h700, 32'h0, 32'h0, "R11_take");
    drive(1'b0, 1'b1, 6'h0, 32'h700, 32'h0, 32'h0, "R11_hold");
    drive(1'b0, 1'b1, 6'h0, 32'h700, 32'h0, 32'h0, "R11_hold");
    drive(1'b0, 1'b0, 6'h0, 32'h700, 32'h0, 32'h0, "R11_hold");
    // R9 PSW never updated: entries alternate with blind cycles
    for (int i = 0; i < 4; i++)
      drive(1'b0, 1'b0, 6'h04, 32'h800 + i, 32'h0, 32'h0, "R9_alt");
    idle(2, 32'h0, "R9_idle");
    // R10 async reset drops a pending NMI
    drive(1'b0, 1'b1, 6'h0, 32'h0, 32'h80, 32'h0, "R10_pend");
    drive(1'b0, 1'b0, 6'h0, 32'h0, 32'h80, 32'h0, "R10_pend");
    @(posedge clk); #1;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(redirect_o === 1'b0 && target_o === 32'h0, "R10", "async clear", target_o, 32'h0);
    m_prev = 1'b0; m_pend = 1'b0; m_busy = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    idle(3, 32'h0, "R10_no_nmi");
    repeat (3) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R9", "queue drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule